// File: doc/BRIEF.md
# Coalescing Nonvolatile Write Controller

This block stands between a processor that writes single bytes and a slow nonvolatile store whose only write operation programs a whole aligned 8-byte group and then keeps the store occupied for a long, fixed time. Its purpose is to reduce how often the store is physically programmed. It does this in two ways. First, a write whose byte already holds the value being written is acknowledged and then dropped. Second, changed bytes collect in a one-group staging buffer, so that a run of writes to one group costs a single program operation. A simple behavioural array of 64-bit words, cleared at reset, stands in for the store inside the block.

The control state machine has three states. `ST_READY` accepts byte writes and merges each one into the staging buffer. `ST_LAUNCH` lasts one cycle: it writes the merged group into the array, raises `prog_pulse` and starts the program timer. `ST_PROG` waits for the timer to finish. The transition READY→LAUNCH has four named causes, checked in this priority order:
- MISS: a request addresses a group other than the staged one.
- FULL: all eight lanes have become dirty.
- FLUSH: `flush` is high while something is staged.
- IDLE: the idle timeout expires.

LAUNCH→PROG is unconditional. PROG→READY happens in the timer's final cycle, and that transition also empties the staging buffer. The read port always returns the value a future read of the store will see, staged bytes included. A sequential download therefore needs no special handling.

Top module: `nvm_coalesce_wr`

## Requirements
- R1: After reset, `req_ready`=1, `busy`=0, `prog_pulse`=0, `prog_count`=0, and every byte reads as 0x00.
- R2: A write whose data equals the byte the read port currently shows for that address is accepted in one cycle and changes nothing. No program operation follows, whether from the idle timeout or from a later `flush`.
- R3: Byte lane = `addr[2:0]` and group = `addr[AW-1:3]`. Once all eight lanes of the staged group are dirty, exactly one program operation starts. It starts in the cycle after the eighth changing write is accepted, whatever order the lanes were written in.
- R4: Writing 4096 sequential bytes, each different from its stored value, produces exactly 512 program operations.
- R5: A request to a group other than the staged one sees `req_ready`=0. The staged group is launched first, and the request is accepted exactly `PROG_CYCLES`+1 cycles after it was first presented.
- R6: Lanes that were not written in the staged group keep their stored contents across the program operation.
- R7: `flush` high in `ST_READY` while a group is staged launches that group in the next cycle. `flush` has no effect when nothing is staged.
- R8: When a group is staged and no write is accepted for `IDLE_CYCLES` consecutive ready cycles, the group is launched in the following cycle.
- R9: `busy` stays high for exactly `PROG_CYCLES` cycles per program operation, and `req_ready` is 0 throughout.
- R10: While a program operation runs, reads of the staged group return the buffered bytes. After it ends, the store holds the same values.
- R11: `prog_pulse` is high for exactly one cycle per program operation, and `prog_count` rises by exactly one in the cycle after each pulse.
- R12: A second write to a dirty lane replaces the buffered byte. The redundancy test for that lane compares against the buffered byte, not the stored one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte write request |
| req_addr | input | AW | Byte address of the request |
| req_data | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| flush | input | 1 | Launch the staged group now |
| rd_addr | input | AW | Byte address to read (combinational) |
| rd_data | output | 8 | Current value at rd_addr, staged bytes included |
| busy | output | 1 | A program operation is occupying the store |
| prog_pulse | output | 1 | One-cycle strobe at the start of each program operation |
| prog_count | output | CNT_W | Number of program operations since reset |

## Verification
Each result has a fixed due time, counted from the clock edge at which the triggering write or flush is accepted:
- The launch caused by a full group or a flush is visible in the cycle right after that edge, with `prog_pulse` and `busy` both high.
- `prog_count` rises one cycle later.
- `busy` then falls exactly `PROG_CYCLES` cycles after it rose.
- An idle launch appears in the cycle after the `IDLE_CYCLES`-th quiet cycle.
- A request to another group waits `PROG_CYCLES`+1 cycles before it is accepted.

The bench changes inputs on falling edges and samples registered outputs at the falling edge of the cycle in which they are due. It waits a short settle time only for the combinational read path. Where a window is being measured, it counts cycles exactly rather than sampling "some time later".

// File: rtl/nvwc_pkg.sv
package nvwc_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 3;
    localparam int WORD_W = LANES * 8;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_PROG   = 2'd2
    } nvwc_state_t;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_MISS  = 3'd1,
        CAUSE_FULL  = 3'd2,
        CAUSE_FLUSH = 3'd3,
        CAUSE_IDLE  = 3'd4
    } nvwc_cause_t;

endpackage

// File: rtl/nvwc_store.sv
// Behavioural nonvolatile array, one 64-bit word per group, cleared by reset.
module nvwc_store #(
    parameter int GW = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [GW-1:0]              wr_grp,
    input  logic [nvwc_pkg::WORD_W-1:0] wr_word,
    input  logic [GW-1:0]              rd_grp_a,
    output logic [nvwc_pkg::WORD_W-1:0] rd_word_a,
    input  logic [GW-1:0]              rd_grp_b,
    output logic [nvwc_pkg::WORD_W-1:0] rd_word_b
);
    localparam int DEPTH = 1 << GW;

    logic [nvwc_pkg::WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_grp] <= wr_word;
        end
    end

    assign rd_word_a = cells[rd_grp_a];
    assign rd_word_b = cells[rd_grp_b];
endmodule

// File: rtl/nvwc_prog_timer.sv
// Counts the fixed occupancy of one program operation.
module nvwc_prog_timer #(
    parameter int PROG_CYCLES = 4000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= TW'(PROG_CYCLES - 1);
        end else if (remain != '0) begin
            remain <= remain - TW'(1);
        end
    end

    assign last = (remain == TW'(1));
endmodule

// File: rtl/nvwc_idle_timer.sv
// Expires after IDLE_CYCLES consecutive cycles with run high.
module nvwc_idle_timer #(
    parameter int IDLE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);

    logic [IW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (!run) begin
            quiet <= '0;
        end else if (quiet != IW'(IDLE_CYCLES - 1)) begin
            quiet <= quiet + IW'(1);
        end
    end

    assign expire = run && (quiet == IW'(IDLE_CYCLES - 1));
endmodule

// File: rtl/nvm_coalesce_wr.sv
module nvm_coalesce_wr #(
    parameter int AW          = 12,
    parameter int PROG_CYCLES = 4000000,
    parameter int IDLE_CYCLES = 1024,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [7:0]       req_data,
    output logic             req_ready,
    input  logic             flush,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             prog_pulse,
    output logic [CNT_W-1:0] prog_count
);
    import nvwc_pkg::*;

    localparam int GW = AW - LANE_W;

    nvwc_state_t state, state_nx;
    nvwc_cause_t cause;

    logic              pend_valid;
    logic [GW-1:0]     pend_grp;
    logic [WORD_W-1:0] pend_data;
    logic [LANES-1:0]  pend_dirty;

    logic [GW-1:0]     req_grp;
    logic [LANE_W-1:0] req_lane;
    logic [LANES-1:0]  req_lane_bit;
    logic [GW-1:0]     rd_grp;
    logic [LANE_W-1:0] rd_lane;

    logic [GW-1:0]     cmp_grp;
    logic [WORD_W-1:0] cmp_word;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] merged_word;

    logic       hit_pend, miss_pend;
    logic [7:0] cur_byte;
    logic       accept, changes;
    logic       pend_valid_nx;
    logic [LANES-1:0] dirty_nx;

    logic tmr_start, tmr_last;
    logic idle_run, idle_expire;
    logic store_wr;

    // Address split
    assign req_grp      = req_addr[AW-1:LANE_W];
    assign req_lane     = req_addr[LANE_W-1:0];
    assign req_lane_bit = LANES'(1) << req_lane;
    assign rd_grp       = rd_addr[AW-1:LANE_W];
    assign rd_lane      = rd_addr[LANE_W-1:0];

    // Compare port follows the request while ready, the staged group otherwise
    assign cmp_grp = (state == ST_READY) ? req_grp : pend_grp;

    nvwc_store #(.GW(GW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (store_wr),
        .wr_grp    (pend_grp),
        .wr_word   (merged_word),
        .rd_grp_a  (cmp_grp),
        .rd_word_a (cmp_word),
        .rd_grp_b  (rd_grp),
        .rd_word_b (rd_word)
    );

    nvwc_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_ptmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .last  (tmr_last)
    );

    nvwc_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_itmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (idle_run),
        .expire (idle_expire)
    );

    // Merge: dirty lanes from the buffer, clean lanes refilled from the store
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged_word[g*8 +: 8] = pend_dirty[g] ? pend_data[g*8 +: 8]
                                                     : cmp_word[g*8 +: 8];
    end

    // Request-side decode
    always_comb begin
        hit_pend  = pend_valid && (req_grp == pend_grp);
        miss_pend = pend_valid && !hit_pend;
        cur_byte  = (hit_pend && pend_dirty[req_lane]) ? pend_data[req_lane*8 +: 8]
                                                       : cmp_word[req_lane*8 +: 8];
        accept    = req_valid && req_ready;
        changes   = accept && (req_data != cur_byte);
        pend_valid_nx = pend_valid || changes;
        dirty_nx  = changes ? (pend_dirty | req_lane_bit) : pend_dirty;
        idle_run  = (state == ST_READY) && pend_valid && !accept;
    end

    // Launch cause, in priority order
    always_comb begin
        cause = CAUSE_NONE;
        if (state == ST_READY) begin
            if (req_valid && miss_pend)
                cause = CAUSE_MISS;
            else if (changes && (dirty_nx == '1))
                cause = CAUSE_FULL;
            else if (flush && pend_valid_nx)
                cause = CAUSE_FLUSH;
            else if (idle_expire)
                cause = CAUSE_IDLE;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY:  if (cause != CAUSE_NONE) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_PROG;
            ST_PROG:   if (tmr_last) state_nx = ST_READY;
            default:   state_nx = ST_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    // Outputs per state
    always_comb begin
        req_ready  = 1'b0;
        prog_pulse = 1'b0;
        busy       = 1'b1;
        tmr_start  = 1'b0;
        store_wr   = 1'b0;
        unique case (state)
            ST_READY: begin
                req_ready = !miss_pend;
                busy      = 1'b0;
            end
            ST_LAUNCH: begin
                prog_pulse = 1'b1;
                tmr_start  = 1'b1;
                store_wr   = 1'b1;
            end
            ST_PROG: ;
            default: busy = 1'b0;
        endcase
    end

    // Staging buffer and operation counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_grp   <= '0;
            pend_data  <= '0;
            pend_dirty <= '0;
            prog_count <= '0;
        end else begin
            if (changes) begin
                pend_valid <= 1'b1;
                pend_grp   <= req_grp;
                pend_data[req_lane*8 +: 8] <= req_data;
                pend_dirty <= dirty_nx;
            end
            if (state == ST_PROG && tmr_last) begin
                pend_valid <= 1'b0;
                pend_dirty <= '0;
            end
            if (state == ST_LAUNCH) begin
                prog_count <= prog_count + CNT_W'(1);
            end
        end
    end

    // Read port sees staged bytes first
    always_comb begin
        if (pend_valid && (rd_grp == pend_grp) && pend_dirty[rd_lane])
            rd_data = pend_data[rd_lane*8 +: 8];
        else
            rd_data = rd_word[rd_lane*8 +: 8];
    end
endmodule

// File: rtl/nvwc_chk.sv
module nvwc_chk #(
    parameter int PROG_CYCLES = 4000000,
    parameter int CNT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             busy,
    input logic             prog_pulse,
    input logic [CNT_W-1:0] prog_count
);
    int busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == PROG_CYCLES));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |=> !prog_pulse);

    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |=> (prog_count == $past(prog_count) + CNT_W'(1)));

    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_pulse |=> $stable(prog_count));

    assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> prog_pulse);

    assert_ready_after_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> req_ready);
endmodule

bind nvm_coalesce_wr nvwc_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .busy       (busy),
    .prog_pulse (prog_pulse),
    .prog_count (prog_count)
);

// File: tb/sim_nvm_coalesce_wr.sv
`timescale 1ns/1ps
module sim_nvm_coalesce_wr;
    localparam int AW = 12;
    localparam int PC = 16;
    localparam int IC = 40;
    localparam int CW = 16;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_ready;
    logic          flush = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic          prog_pulse;
    logic [CW-1:0] prog_count;

    always #2.5 clk = ~clk;

    nvm_coalesce_wr #(.AW(AW), .PROG_CYCLES(PC), .IDLE_CYCLES(IC), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .flush(flush),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .prog_pulse(prog_pulse), .prog_count(prog_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [NB];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output int waited);
        req_valid = 1'b1; req_addr = a; req_data = d; waited = 0;
        forever begin
            #1;
            if (req_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        model[a] = d;
    endtask

    task automatic wr1(input logic [AW-1:0] a, input logic [7:0] d);
        int w;
        wr(a, d, w);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == model[a], req, $sformatf("read @%0h", a), v, model[a]);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(prog_pulse == 1'b0, "R1", "pulse", prog_pulse, 0);
        chk(prog_count == '0, "R1", "count", prog_count, 0);
        rd_chk(12'h000, "R1");
        rd_chk(12'hFFF, "R1");
    endtask

    task automatic t_redundant();
        logic [CW-1:0] c0 = prog_count;
        wr1(12'h010, 8'h00);
        nclk(IC + 5);
        chk(prog_count == c0, "R2", "no program after idle", prog_count, c0);
        do_flush();
        chk(busy == 1'b0, "R7", "flush with nothing staged", busy, 0);
        nclk(3);
        chk(prog_count == c0, "R2", "no program after flush", prog_count, c0);
        rd_chk(12'h010, "R2");
    endtask

    task automatic t_full();
        int order [8] = '{3, 0, 7, 5, 1, 6, 2, 4};
        logic [CW-1:0] c0 = prog_count;
        logic [7:0] v;
        int nb = 0;
        for (int k = 0; k < 8; k++) begin
            if (k == 7) chk(busy == 1'b0, "R3", "not launched at 7 lanes", busy, 0);
            wr1(12'h040 + AW'(order[k]), 8'hA0 + 8'(order[k]));
        end
        chk(prog_pulse == 1'b1, "R3", "pulse after 8th lane", prog_pulse, 1);
        chk(busy == 1'b1, "R3", "busy after 8th lane", busy, 1);
        chk(prog_count == c0, "R11", "count before step", prog_count, c0);
        while (busy) begin
            nb++;
            if (nb == 2) begin
                chk(prog_pulse == 1'b0, "R11", "pulse one cycle", prog_pulse, 0);
                chk(prog_count == c0 + 1, "R11", "count step", prog_count, c0 + 1);
                chk(req_ready == 1'b0, "R9", "ready low while busy", req_ready, 0);
            end
            if (nb == 4) begin
                rd(12'h045, v);
                chk(v == 8'hA5, "R10", "staged read while busy", v, 8'hA5);
            end
            @(negedge clk);
        end
        chk(nb == PC, "R9", "busy length", nb, PC);
        chk(prog_count == c0 + 1, "R3", "one program per group", prog_count, c0 + 1);
        for (int k = 0; k < 8; k++) rd_chk(12'h040 + AW'(k), "R10");
    endtask

    task automatic t_partial();
        logic [CW-1:0] c0 = prog_count;
        wr1(12'h042, 8'h5C);
        chk(busy == 1'b0, "R7", "no launch before flush", busy, 0);
        do_flush();
        chk(busy == 1'b1, "R7", "launch on flush", busy, 1);
        wait_ready();
        chk(prog_count == c0 + 1, "R7", "count after flush", prog_count, c0 + 1);
        for (int k = 0; k < 8; k++) rd_chk(12'h040 + AW'(k), "R6");
    endtask

    task automatic t_miss();
        logic [CW-1:0] c0 = prog_count;
        int w;
        wr1(12'h080, 8'h11);
        wr(12'h100, 8'h22, w);
        chk(w == PC + 1, "R5", "stall cycles on group miss", w, PC + 1);
        chk(prog_count == c0 + 1, "R5", "old group launched first", prog_count, c0 + 1);
        chk(busy == 1'b0, "R5", "new group only staged", busy, 0);
        do_flush();
        wait_ready();
        chk(prog_count == c0 + 2, "R5", "second group launched", prog_count, c0 + 2);
        rd_chk(12'h080, "R5");
        rd_chk(12'h100, "R5");
    endtask

    task automatic t_idle();
        logic [CW-1:0] c0 = prog_count;
        wr1(12'h200, 8'h5A);
        nclk(IC - 1);
        chk(busy == 1'b0, "R8", "quiet before timeout", busy, 0);
        nclk(1);
        chk(busy == 1'b1, "R8", "launch on timeout", busy, 1);
        chk(prog_pulse == 1'b1, "R8", "pulse on timeout", prog_pulse, 1);
        wait_ready();
        chk(prog_count == c0 + 1, "R8", "count after timeout", prog_count, c0 + 1);
        rd_chk(12'h200, "R8");
    endtask

    task automatic t_overwrite();
        logic [CW-1:0] c0 = prog_count;
        wr1(12'h305, 8'h33);
        rd_chk(12'h305, "R12");
        wr1(12'h305, 8'h44);
        rd_chk(12'h305, "R12");
        wr1(12'h305, 8'h44);
        wr1(12'h305, 8'h00);
        rd_chk(12'h305, "R12");
        chk(busy == 1'b0, "R12", "still staged", busy, 0);
        do_flush();
        chk(busy == 1'b1, "R12", "restored lane still dirty", busy, 1);
        wait_ready();
        chk(prog_count == c0 + 1, "R12", "count", prog_count, c0 + 1);
        rd_chk(12'h305, "R12");
    endtask

    task automatic t_download();
        logic [CW-1:0] c0 = prog_count;
        for (int i = 0; i < NB; i++) begin
            wr1(AW'(i), model[i] ^ (8'h01 + {1'b0, 7'(i)}));
        end
        do_flush();
        wait_ready();
        chk(prog_count == c0 + 512, "R4", "programs for 4096 bytes", prog_count, c0 + 512);
        for (int i = 0; i < NB; i += 273) rd_chk(AW'(i), "R4");
    endtask

    initial begin
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        nclk(3);
        rst_n = 1'b1;
        nclk(1);
        t_reset();
        t_redundant();
        t_full();
        t_partial();
        t_miss();
        t_idle();
        t_overwrite();
        t_download();
        nclk(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule